// File: doc/BRIEF.md
# Halt and Wake-up Controller

This block manages the low-power halt state of a small microcontroller. A halt strobe from the core stops the system clock enable and records the entry in a power-down flag. A set of wake sources brings the clock back: an interrupt request, a falling edge on a wake-enabled I/O pin, an external reset, or an overflow of the built-in watchdog counter. Only the watchdog wake asks for a partial reset, which covers the program counter and stack pointer.

The block runs on an always-on clock `clk`. The controlled core is clocked only while `sys_clk_en` is high. Pin edges are detected on this always-on clock, so a pin can wake the core while the core's own clock is stopped. The watchdog advances on every `clk` cycle while the core runs. During halt it keeps counting only when its source select names the always-on oscillator.

The status flags tell software why it woke. `pdf` shows that a halt happened and has not been cleared since. `to_flag` shows that the watchdog expired.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After `rst`, `sys_clk_en` is 1 and `pdf`, `to_flag`, `full_rst_req` and `pcsp_rst_req` are all 0.
- R2: While running, a `halt_stb` cycle drops `sys_clk_en` at the next edge, sets `pdf`, clears `to_flag` and clears the watchdog count.
- R3: A `clr_wdt_stb` cycle clears `pdf` and restarts the watchdog count from 0, whether the core is running or halted.
- R4: While halted, a falling edge (sample 1 then sample 0) on a port A pin whose bit in `pa_wake_en` is 1 raises `sys_clk_en` at the third clock edge after the pin goes low. No reset request is made.
- R5: Pins of `px_pins` are woken in groups of four: nibble n is bits 4n+3..4n and is enabled by `px_wake_en[n]`. A falling edge on a pin whose enable is 0 leaves the core halted.
- R6: While halted, `irq` high at a clock edge raises `sys_clk_en` at that edge, with no reset request.
- R7: `ext_rst_in` high at an edge gives a one-cycle `full_rst_req` pulse and `sys_clk_en` = 1, in both modes. `pdf` and `to_flag` keep their values.
- R8: With `wdt_src_osc` = 1 (own oscillator), a halted watchdog keeps counting. Its overflow, WDT_LIMIT edges after the last clear, sets `to_flag`, raises `sys_clk_en` and gives a one-cycle `pcsp_rst_req`. `pdf` is kept.
- R9: With `wdt_src_osc` = 0 (system clock), the watchdog count is frozen while halted. No time-out can occur in that state.
- R10: While running, a watchdog overflow WDT_LIMIT edges after the last clear sets `to_flag` and gives a one-cycle `full_rst_req`.
- R11: When a wake event arrives in the same cycle as `halt_stb`, the core halts at that edge and wakes at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| ext_rst_in | input | 1 | External reset request, synchronous |
| halt_stb | input | 1 | Halt instruction strobe |
| clr_wdt_stb | input | 1 | Clear-watchdog command strobe |
| wdt_src_osc | input | 1 | 1: watchdog on its own oscillator; 0: on system clock |
| irq | input | 1 | Interrupt request |
| pa_pins | input | NUM_PA | Port A pin levels |
| pa_wake_en | input | NUM_PA | Per-pin wake enable for port A |
| px_pins | input | 4*NUM_NIB | Other port pin levels |
| px_wake_en | input | NUM_NIB | Per-nibble wake enable for other ports |
| sys_clk_en | output | 1 | System clock enable |
| pdf | output | 1 | Power-down flag |
| to_flag | output | 1 | Watchdog time-out flag |
| full_rst_req | output | 1 | Full system reset request pulse |
| pcsp_rst_req | output | 1 | Program counter / stack pointer reset pulse |

## Verification
The main wake function is tried with each wake source in isolation. An interrupt wakes the core in the same cycle. An enabled port A pin wakes it after a fixed synchronizer delay. An enabled nibble pin also wakes it. Pins whose per-pin or per-nibble enable is off must not wake it, which tells the two enable granularities apart.

The watchdog is run in three ways: halted on its own oscillator, halted on the system clock, and running. These separate the partial-reset wake, the frozen count and the full-reset time-out. A clear issued partway through a halt moves the overflow later by exactly the elapsed count. A halt that coincides with an interrupt shows that the wake is deferred by one cycle and not lost.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HALT = 1'b1
  } hwc_state_e;

  localparam int unsigned NIB_W = 4;
endpackage

// File: rtl/hwc_pin_wake.sv
// Two-flop synchronizer plus previous-sample stage, falling-edge detect,
// wake enable applied per group of GROUP pins.
module hwc_pin_wake #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned GROUP    = 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_PINS-1:0]            pins,
  input  logic [(NUM_PINS/GROUP)-1:0]    grp_en,
  output logic                           any_fall
);
  localparam int unsigned NUM_GRP = NUM_PINS / GROUP;

  logic [NUM_PINS-1:0] sync1_q, sync2_q, prev_q;
  logic [NUM_PINS-1:0] pin_en;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    for (genvar p = 0; p < GROUP; p++) begin : g_pin
      assign pin_en[g*GROUP + p] = grp_en[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= '1;
      sync2_q <= '1;
      prev_q  <= '1;
    end else begin
      sync1_q <= pins;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign any_fall = |(prev_q & ~sync2_q & pin_en);
endmodule

// File: rtl/hwc_wdt.sv
// Watchdog counter; overflow when the count would pass LIMIT-1.
module hwc_wdt #(
  parameter int unsigned LIMIT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic ovf
);
  localparam int unsigned CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  assign ovf = inc && !clr && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst || clr || ovf) cnt_q <= '0;
    else if (inc)          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hwc_seq.sv
// Run/halt state, status flags and reset requests.
module hwc_seq
  import hwc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ext_rst_in,
  input  logic halt_stb,
  input  logic clr_wdt_stb,
  input  logic wake_evt,
  input  logic wdt_ovf,
  output logic running,
  output logic halt_entry,
  output logic pdf,
  output logic to_flag,
  output logic full_rst_req,
  output logic pcsp_rst_req
);
  hwc_state_e state_q;
  logic       hold_q;

  assign running    = (state_q == ST_RUN);
  assign halt_entry = running && halt_stb && !ext_rst_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_RUN;
      hold_q       <= 1'b0;
      pdf          <= 1'b0;
      to_flag      <= 1'b0;
      full_rst_req <= 1'b0;
      pcsp_rst_req <= 1'b0;
    end else begin
      full_rst_req <= 1'b0;
      pcsp_rst_req <= 1'b0;
      if (clr_wdt_stb) pdf <= 1'b0;
      if (ext_rst_in) begin
        state_q      <= ST_RUN;
        hold_q       <= 1'b0;
        full_rst_req <= 1'b1;
      end else if (state_q == ST_RUN) begin
        if (halt_stb) begin
          state_q <= ST_HALT;
          pdf     <= 1'b1;
          to_flag <= 1'b0;
          hold_q  <= wake_evt;
        end else if (wdt_ovf) begin
          to_flag      <= 1'b1;
          full_rst_req <= 1'b1;
        end
      end else begin
        if (wdt_ovf) begin
          to_flag      <= 1'b1;
          pcsp_rst_req <= 1'b1;
          state_q      <= ST_RUN;
          hold_q       <= 1'b0;
        end else if (wake_evt || hold_q) begin
          state_q <= ST_RUN;
          hold_q  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl #(
  parameter int unsigned NUM_PA    = 8,
  parameter int unsigned NUM_NIB   = 2,
  parameter int unsigned WDT_LIMIT = 4096
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ext_rst_in,
  input  logic                   halt_stb,
  input  logic                   clr_wdt_stb,
  input  logic                   wdt_src_osc,
  input  logic                   irq,
  input  logic [NUM_PA-1:0]      pa_pins,
  input  logic [NUM_PA-1:0]      pa_wake_en,
  input  logic [4*NUM_NIB-1:0]   px_pins,
  input  logic [NUM_NIB-1:0]     px_wake_en,
  output logic                   sys_clk_en,
  output logic                   pdf,
  output logic                   to_flag,
  output logic                   full_rst_req,
  output logic                   pcsp_rst_req
);
  import hwc_pkg::*;

  logic pa_fall, px_fall, wake_evt;
  logic running, halt_entry, wdt_ovf, wdt_clr, wdt_inc;

  hwc_pin_wake #(.NUM_PINS(NUM_PA), .GROUP(1)) u_pa_wake (
    .clk(clk), .rst(rst), .pins(pa_pins), .grp_en(pa_wake_en), .any_fall(pa_fall)
  );

  hwc_pin_wake #(.NUM_PINS(NIB_W*NUM_NIB), .GROUP(NIB_W)) u_px_wake (
    .clk(clk), .rst(rst), .pins(px_pins), .grp_en(px_wake_en), .any_fall(px_fall)
  );

  assign wake_evt = pa_fall || px_fall || irq;
  assign wdt_clr  = clr_wdt_stb || ext_rst_in || halt_entry;
  assign wdt_inc  = running || wdt_src_osc;

  hwc_wdt #(.LIMIT(WDT_LIMIT)) u_wdt (
    .clk(clk), .rst(rst), .clr(wdt_clr), .inc(wdt_inc), .ovf(wdt_ovf)
  );

  hwc_seq u_seq (
    .clk(clk), .rst(rst), .ext_rst_in(ext_rst_in), .halt_stb(halt_stb),
    .clr_wdt_stb(clr_wdt_stb), .wake_evt(wake_evt), .wdt_ovf(wdt_ovf),
    .running(running), .halt_entry(halt_entry), .pdf(pdf), .to_flag(to_flag),
    .full_rst_req(full_rst_req), .pcsp_rst_req(pcsp_rst_req)
  );

  assign sys_clk_en = running;
endmodule

// File: rtl/hwc_checker.sv
module hwc_checker (
  input logic clk,
  input logic rst,
  input logic ext_rst_in,
  input logic halt_stb,
  input logic clr_wdt_stb,
  input logic wdt_src_osc,
  input logic irq,
  input logic sys_clk_en,
  input logic pdf,
  input logic to_flag,
  input logic full_rst_req,
  input logic pcsp_rst_req
);
  assert_halt_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (sys_clk_en && halt_stb && !ext_rst_in) |=> (!sys_clk_en && pdf && !to_flag));

  assert_clear_pdf_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_wdt_stb && !(halt_stb && sys_clk_en)) |=> !pdf);

  assert_irq_wake_R6: assert property (@(posedge clk) disable iff (rst)
    (!sys_clk_en && irq && !ext_rst_in) |=> (sys_clk_en && !full_rst_req));

  assert_ext_reset_R7: assert property (@(posedge clk) disable iff (rst)
    ext_rst_in |=> (full_rst_req && sys_clk_en));

  assert_partial_reset_R8: assert property (@(posedge clk) disable iff (rst)
    pcsp_rst_req |-> (sys_clk_en && to_flag && !full_rst_req));

  assert_frozen_wdt_R9: assert property (@(posedge clk) disable iff (rst)
    (!sys_clk_en && !wdt_src_osc && !ext_rst_in) |=> !pcsp_rst_req);

  assert_full_timeout_R10: assert property (@(posedge clk) disable iff (rst)
    (full_rst_req && !$past(ext_rst_in)) |-> to_flag);
endmodule

bind halt_wake_ctrl hwc_checker u_chk (
  .clk(clk), .rst(rst), .ext_rst_in(ext_rst_in), .halt_stb(halt_stb),
  .clr_wdt_stb(clr_wdt_stb), .wdt_src_osc(wdt_src_osc), .irq(irq),
  .sys_clk_en(sys_clk_en), .pdf(pdf), .to_flag(to_flag),
  .full_rst_req(full_rst_req), .pcsp_rst_req(pcsp_rst_req)
);

// File: tb/halt_wake_ctrl_tb.sv
module halt_wake_ctrl_tb;
  localparam int NUM_PA  = 8;
  localparam int NUM_NIB = 2;
  localparam int LIM     = 32;

  localparam logic [2:0] OP_IDLE = 3'd0, OP_CLR = 3'd1, OP_HALT = 3'd2, OP_IRQ = 3'd3,
                         OP_PAF  = 3'd4, OP_PXF = 3'd5, OP_EXT  = 3'd6, OP_HIRQ = 3'd7;

  // {op[3], idx[4], wait[4], req[4], expect{clk_en,pdf,to,full,pcsp}[5]}
  localparam int NV = 21;
  localparam logic [19:0] VEC [NV] = '{
    {OP_CLR,  4'd0, 4'd0, 4'd3,  5'b10000},  // R3 clear while running
    {OP_HALT, 4'd0, 4'd0, 4'd2,  5'b01000},  // R2 halt entry
    {OP_IDLE, 4'd0, 4'd5, 4'd2,  5'b01000},  // R2 stays halted
    {OP_IRQ,  4'd0, 4'd0, 4'd6,  5'b11000},  // R6 irq wake
    {OP_CLR,  4'd0, 4'd0, 4'd3,  5'b10000},  // R3
    {OP_HALT, 4'd0, 4'd0, 4'd2,  5'b01000},  // R2
    {OP_PAF,  4'd3, 4'd2, 4'd4,  5'b11000},  // R4 enabled port A pin
    {OP_CLR,  4'd0, 4'd0, 4'd3,  5'b10000},  // R3
    {OP_HALT, 4'd0, 4'd0, 4'd2,  5'b01000},  // R2
    {OP_PAF,  4'd5, 4'd4, 4'd5,  5'b01000},  // R5 disabled port A pin
    {OP_PXF,  4'd1, 4'd4, 4'd5,  5'b01000},  // R5 disabled low nibble
    {OP_IDLE, 4'd0, 4'd0, 4'd5,  5'b01000},  // R5
    {OP_PXF,  4'd6, 4'd2, 4'd5,  5'b11000},  // R5 enabled high nibble
    {OP_IDLE, 4'd0, 4'd0, 4'd5,  5'b11000},  // R5
    {OP_CLR,  4'd0, 4'd0, 4'd3,  5'b10000},  // R3
    {OP_EXT,  4'd0, 4'd0, 4'd7,  5'b10010},  // R7 ext reset while running
    {OP_HALT, 4'd0, 4'd0, 4'd2,  5'b01000},  // R2
    {OP_EXT,  4'd0, 4'd0, 4'd7,  5'b11010},  // R7 ext reset wakes, pdf kept
    {OP_IDLE, 4'd0, 4'd0, 4'd7,  5'b11000},  // R7 pulse is one cycle
    {OP_HIRQ, 4'd0, 4'd0, 4'd11, 5'b01000},  // R11 halt wins first
    {OP_IDLE, 4'd0, 4'd0, 4'd11, 5'b11000}   // R11 wake next cycle
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_rst_in = 1'b0, halt_stb = 1'b0, clr_wdt_stb = 1'b0, wdt_src_osc = 1'b0, irq = 1'b0;
  logic [NUM_PA-1:0]    pa_pins = '1;
  logic [NUM_PA-1:0]    pa_wake_en = 8'h0F;
  logic [4*NUM_NIB-1:0] px_pins = '1;
  logic [NUM_NIB-1:0]   px_wake_en = 2'b10;
  logic sys_clk_en, pdf, to_flag, full_rst_req, pcsp_rst_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  halt_wake_ctrl #(.NUM_PA(NUM_PA), .NUM_NIB(NUM_NIB), .WDT_LIMIT(LIM)) u_dut (
    .clk(clk), .rst(rst), .ext_rst_in(ext_rst_in), .halt_stb(halt_stb),
    .clr_wdt_stb(clr_wdt_stb), .wdt_src_osc(wdt_src_osc), .irq(irq),
    .pa_pins(pa_pins), .pa_wake_en(pa_wake_en), .px_pins(px_pins), .px_wake_en(px_wake_en),
    .sys_clk_en(sys_clk_en), .pdf(pdf), .to_flag(to_flag),
    .full_rst_req(full_rst_req), .pcsp_rst_req(pcsp_rst_req)
  );

  task automatic chk(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {sys_clk_en, pdf, to_flag, full_rst_req, pcsp_rst_req};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {clk_en,pdf,to,full,pcsp} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Drive one op for one edge, then release it; ends at the negedge after that edge.
  task automatic apply_op(input logic [2:0] op, input logic [3:0] idx);
    pa_pins = '1;
    px_pins = '1;
    case (op)
      OP_CLR:  clr_wdt_stb = 1'b1;
      OP_HALT: halt_stb = 1'b1;
      OP_IRQ:  irq = 1'b1;
      OP_PAF:  pa_pins[idx[2:0]] = 1'b0;
      OP_PXF:  px_pins[idx[2:0]] = 1'b0;
      OP_EXT:  ext_rst_in = 1'b1;
      OP_HIRQ: begin halt_stb = 1'b1; irq = 1'b1; end
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    clr_wdt_stb = 1'b0; halt_stb = 1'b0; irq = 1'b0; ext_rst_in = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step(1);
    chk("R1", 5'b10000);

    for (int v = 0; v < NV; v++) begin
      apply_op(VEC[v][19:17], VEC[v][16:13]);
      if (VEC[v][12:9] != 0) step(int'(VEC[v][12:9]));
      chk($sformatf("R%0d vec%0d", VEC[v][8:5], v), VEC[v][4:0]);
    end

    // R8: halted on own oscillator, overflow after LIM edges
    wdt_src_osc = 1'b1;
    apply_op(OP_HALT, 4'd0);
    step(LIM - 1);
    chk("R8 before overflow", 5'b01000);
    step(1);
    chk("R8 overflow wake", 5'b11101);
    step(1);
    chk("R8 pulse one cycle", 5'b11100);

    // R9: halted on system clock, frozen
    wdt_src_osc = 1'b0;
    apply_op(OP_HALT, 4'd0);
    chk("R2 halt clears to", 5'b01000);
    step(60);
    chk("R9 frozen", 5'b01000);
    apply_op(OP_IRQ, 4'd0);
    chk("R6 irq wake", 5'b11000);

    // R3: clear during halt restarts the count
    wdt_src_osc = 1'b1;
    apply_op(OP_HALT, 4'd0);
    step(20);
    apply_op(OP_CLR, 4'd0);
    chk("R3 clear while halted", 5'b00000);
    step(LIM - 1);
    chk("R3 count restarted", 5'b00000);
    step(1);
    chk("R8 overflow after clear", 5'b10101);

    // R10: running overflow
    wdt_src_osc = 1'b0;
    apply_op(OP_CLR, 4'd0);
    chk("R10 cleared", 5'b10100);
    step(LIM - 1);
    chk("R10 before overflow", 5'b10100);
    step(1);
    chk("R10 overflow", 5'b10110);

    // R4: pin wake latency
    apply_op(OP_HALT, 4'd0);
    chk("R2 halt clears to", 5'b01000);
    apply_op(OP_PAF, 4'd0);
    chk("R4 edge +0", 5'b01000);
    step(1);
    chk("R4 edge +1", 5'b01000);
    step(1);
    chk("R4 edge +2 wake", 5'b11000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule